// File: doc/BRIEF.md
# Dual Sample-Rate Timestamp Counters

This block keeps two free-running 64-bit sample counters, one for the receive path and one for the transmit path. Each counter lives in its own sample clock domain and advances once for every sample strobe in that domain, so its value counts samples at the configured sample rate rather than system clock cycles. A single enable level, driven from a control clock domain, starts both counters. Each sample domain has its own synchronizer for that level. Because both domains see the same enable edge, two counters fed at the same sample rate stay within one tick of each other, and that offset does not change while they run.

Lowering the enable returns both counters to zero, and the next enable restarts them from zero. The transmit side can also be given a start time for a timed burst. When the transmit counter reaches that time, the block raises a one-cycle event and disarms. A start time that has already passed when it is armed raises a one-cycle late flag instead.

Top module: `tsc_top`

## Requirements
- R1: While reset is asserted, both counters read zero and the event and late outputs are low.
- R2: Each domain passes the enable through two flops of its own clock. A counter stays at zero until its synchronized enable is high, and the first strobe after that sets it to 1. For the transmit side, with the enable raised between edges and a strobe on every cycle, the count equals k-2 after k transmit edges (k ≥ 2).
- R3: While enabled, a counter rises by exactly one on each of its clock edges where the strobe is high, and it holds its value on edges where the strobe is low.
- R4: Once the enable has been low for three edges of a domain's clock, that counter reads zero, whatever its strobe does. When the enable returns, the counter restarts from zero.
- R5: With both domains at the same clock rate and strobing every cycle, the receive and transmit counts differ by at most one.
- R6: Arming with a start time later than the next transmit count raises the event for exactly one cycle, in the cycle where the transmit count equals that time. No further event follows until the block is armed again.
- R7: Arming with a start time equal to the transmit count that the arming edge produces raises the event in the very next cycle.
- R8: Arming with a start time below the transmit count that the arming edge produces raises the late flag for one cycle and no event.
- R9: Lowering the enable discards a pending schedule, so no event follows when the restarted counter later passes the old start time.
- R10: The event and the late flag are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| tsEnable | input | 1 | Timestamp enable level from the control domain |
| rxClk | input | 1 | Receive sample-domain clock |
| rxStrobe | input | 1 | Receive sample strobe, one per sample |
| txClk | input | 1 | Transmit sample-domain clock |
| txStrobe | input | 1 | Transmit sample strobe, one per sample |
| schedTime | input | 64 | Start time for the scheduled transmit event (txClk domain) |
| schedArm | input | 1 | One-cycle arm request that loads schedTime (txClk domain) |
| rxCount | output | 64 | Receive timestamp counter |
| txCount | output | 64 | Transmit timestamp counter |
| txEvent | output | 1 | One-cycle pulse when the transmit count reaches the armed time |
| txLate | output | 1 | One-cycle pulse when the armed time was already past |

## Verification
The checker watches every cycle for several properties: each counter moves by exactly one or returns to zero, a counter holds when its strobe is low, a counter is cleared after the enable has stayed low through the synchronizer, the late flag appears only right after an arm request, and the event and late outputs never overlap. The bench scenarios cover the rest. They measure the exact enable-to-count latency and the alignment of the two domains. They also sweep strobe patterns and arming offsets on both sides of the current count, which fixes in which cycle the event or late flag appears. Finally, they show that a schedule armed before a disable never fires after the restart.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
  // strobes the per-domain control hands to its datapath
  typedef struct packed {
    logic clr;  // synchronized enable is low: force count to zero
    logic adv;  // synchronized enable high and a sample arrived
  } tsc_stb_t;
endpackage

// File: rtl/tsc_ctrl.sv
`timescale 1ns/1ps
module tsc_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enAsync,
  input  logic              strobe,
  output tsc_pkg::tsc_stb_t stb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic syncEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], enAsync};
  end

  assign syncEn  = syncQ[SYNC_STAGES-1];
  assign stb.clr = !syncEn;
  assign stb.adv = syncEn && strobe;
endmodule

// File: rtl/tsc_count.sv
`timescale 1ns/1ps
module tsc_count #(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsc_pkg::tsc_stb_t stb,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        count <= '0;
    else if (stb.clr) count <= '0;
    else if (stb.adv) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/tsc_sched.sv
`timescale 1ns/1ps
module tsc_sched #(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsc_pkg::tsc_stb_t stb,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  when,
  input  logic              arm,
  output logic              evt,
  output logic              late
);
  logic [CNT_W-1:0] countNext;
  logic [CNT_W-1:0] target;
  logic             armed;

  // value the counter takes at this edge; compares are made against it
  always_comb begin
    if (stb.clr)      countNext = '0;
    else if (stb.adv) countNext = count + CNT_W'(1);
    else              countNext = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      target <= '0;
      evt    <= 1'b0;
      late   <= 1'b0;
    end else begin
      evt  <= 1'b0;
      late <= 1'b0;
      if (stb.clr) begin
        armed <= 1'b0;
      end else if (arm) begin
        target <= when;
        if (when < countNext) begin
          late  <= 1'b1;
          armed <= 1'b0;
        end else if (when == countNext) begin
          evt   <= 1'b1;
          armed <= 1'b0;
        end else begin
          armed <= 1'b1;
        end
      end else if (armed && (countNext == target)) begin
        evt   <= 1'b1;
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tsc_top.sv
`timescale 1ns/1ps
module tsc_top #(
  parameter int CNT_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rstN,
  input  logic             tsEnable,
  input  logic             rxClk,
  input  logic             rxStrobe,
  input  logic             txClk,
  input  logic             txStrobe,
  input  logic [CNT_W-1:0] schedTime,
  input  logic             schedArm,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txCount,
  output logic             txEvent,
  output logic             txLate
);
  localparam int LANES = 2;  // lane 0 receive, lane 1 transmit
  localparam int TX    = 1;

  logic [LANES-1:0]  laneClk;
  logic [LANES-1:0]  laneStb;
  tsc_pkg::tsc_stb_t laneCtl [LANES];
  logic [CNT_W-1:0]  laneCnt [LANES];

  assign laneClk = {txClk, rxClk};
  assign laneStb = {txStrobe, rxStrobe};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
      .clk(laneClk[g]), .rstN(rstN), .enAsync(tsEnable),
      .strobe(laneStb[g]), .stb(laneCtl[g])
    );
    tsc_count #(.CNT_W(CNT_W)) i_count (
      .clk(laneClk[g]), .rstN(rstN), .stb(laneCtl[g]), .count(laneCnt[g])
    );
  end

  tsc_sched #(.CNT_W(CNT_W)) i_sched (
    .clk(txClk), .rstN(rstN), .stb(laneCtl[TX]), .count(laneCnt[TX]),
    .when(schedTime), .arm(schedArm), .evt(txEvent), .late(txLate)
  );

  assign rxCount = laneCnt[0];
  assign txCount = laneCnt[TX];
endmodule

// File: rtl/tsc_checker.sv
`timescale 1ns/1ps
module tsc_checker #(
  parameter int CNT_W = 64
) (
  input logic             rstN,
  input logic             tsEnable,
  input logic             rxClk,
  input logic             rxStrobe,
  input logic             txClk,
  input logic             txStrobe,
  input logic             schedArm,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] txCount,
  input logic             txEvent,
  input logic             txLate
);
  logic [1:0] txAge, rxAge;  // saturating edge counts since reset

  always_ff @(posedge txClk or negedge rstN)
    if (!rstN) txAge <= '0; else if (txAge != 2'd3) txAge <= txAge + 2'd1;
  always_ff @(posedge rxClk or negedge rstN)
    if (!rstN) rxAge <= '0; else if (rxAge != 2'd3) rxAge <= rxAge + 2'd1;

  AST_TX_STEP_ONE: assert property (@(posedge txClk) disable iff (!rstN)
    (txAge != 2'd0 && txCount != $past(txCount)) |-> (txCount == $past(txCount) + CNT_W'(1) || txCount == '0)); // R3
  AST_RX_STEP_ONE: assert property (@(posedge rxClk) disable iff (!rstN)
    (rxAge != 2'd0 && rxCount != $past(rxCount)) |-> (rxCount == $past(rxCount) + CNT_W'(1) || rxCount == '0)); // R3
  AST_TX_HOLD_IDLE: assert property (@(posedge txClk) disable iff (!rstN)
    (txAge != 2'd0 && !$past(txStrobe) && txCount != '0) |-> txCount == $past(txCount)); // R3
  AST_TX_CLEAR_OFF: assert property (@(posedge txClk) disable iff (!rstN)
    (txAge == 2'd3 && !$past(tsEnable, 1) && !$past(tsEnable, 2) && !$past(tsEnable, 3)) |-> txCount == '0); // R4
  AST_RX_CLEAR_OFF: assert property (@(posedge rxClk) disable iff (!rstN)
    (rxAge == 2'd3 && !$past(tsEnable, 1) && !$past(tsEnable, 2) && !$past(tsEnable, 3)) |-> rxCount == '0); // R4
  AST_LATE_ON_ARM: assert property (@(posedge txClk) disable iff (!rstN)
    (txAge != 2'd0 && txLate) |-> $past(schedArm)); // R8
  AST_EVENT_LATE_EXCL: assert property (@(posedge txClk) disable iff (!rstN)
    $onehot0({txEvent, txLate})); // R10
endmodule

bind tsc_top tsc_checker #(.CNT_W(CNT_W)) i_chk (
  .rstN(rstN), .tsEnable(tsEnable), .rxClk(rxClk), .rxStrobe(rxStrobe),
  .txClk(txClk), .txStrobe(txStrobe), .schedArm(schedArm),
  .rxCount(rxCount), .txCount(txCount), .txEvent(txEvent), .txLate(txLate)
);

// File: tb/test_tsc_top.sv
`timescale 1ns/1ps
module test_tsc_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic rstN = 1'b0, tsEnable = 1'b0;
  logic rxClk = 1'b0, txClk = 1'b0;
  logic rxStrobe = 1'b0, txStrobe = 1'b0, schedArm = 1'b0;
  logic [W-1:0] schedTime = '0;
  logic [W-1:0] rxCount, txCount;
  logic txEvent, txLate;

  int nVec = 0, nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) txClk = ~txClk;
  initial begin
    #3;
    forever #(CLK_PERIOD/2) rxClk = ~rxClk;
  end

  tsc_top i_tsc_top (
    .rstN(rstN), .tsEnable(tsEnable), .rxClk(rxClk), .rxStrobe(rxStrobe),
    .txClk(txClk), .txStrobe(txStrobe), .schedTime(schedTime), .schedArm(schedArm),
    .rxCount(rxCount), .txCount(txCount), .txEvent(txEvent), .txLate(txLate)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge txClk);
  endtask

  task automatic checkAlign(input string req);
    longint diff;
    diff = longint'(rxCount) - longint'(txCount);
    check(diff >= -1 && diff <= 1, req, rxCount, txCount);
  endtask

  // arm at offset d from the count the arming edge produces, then watch 8 cycles
  task automatic schedSweep(input int d);
    logic [W-1:0] c;
    bit expEvt, expLate;
    c = txCount;
    schedTime = c + W'(1 + d);
    schedArm = 1'b1;
    for (int m = 1; m <= 8; m++) begin
      tick(1);
      if (m == 1) schedArm = 1'b0;
      expEvt  = (d >= 0) && (m == 1 + d);
      expLate = (d < 0) && (m == 1);
      if (d == 0)     check(txEvent == expEvt, "R7 event on equal time", W'(txEvent), W'(expEvt));
      else if (d > 0) check(txEvent == expEvt, "R6 single event at time", W'(txEvent), W'(expEvt));
      else            check(txEvent == expEvt, "R8 no event when late", W'(txEvent), W'(expEvt));
      check(txLate == expLate, "R8 late flag", W'(txLate), W'(expLate));
      check(!(txEvent && txLate), "R10 exclusive", W'({txEvent, txLate}), W'(0));
    end
  endtask

  initial begin
    logic [W-1:0] c0;
    bit seen;
    tick(3);
    check(txCount == '0, "R1 tx count in reset", txCount, '0);
    check(rxCount == '0, "R1 rx count in reset", rxCount, '0);
    check(!txEvent, "R1 event in reset", W'(txEvent), '0);
    check(!txLate, "R1 late in reset", W'(txLate), '0);
    rstN = 1'b1;
    tick(2);

    // R2 / R5: enable latency and alignment
    rxStrobe = 1'b1;
    txStrobe = 1'b1;
    tsEnable = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      tick(1);
      check(txCount == ((k >= 2) ? W'(k - 2) : W'(0)), "R2 start latency", txCount,
            (k >= 2) ? W'(k - 2) : W'(0));
      checkAlign("R5 rx/tx alignment");
    end

    // R3: every 4-cycle strobe pattern
    for (int p = 0; p < 16; p++) begin
      c0 = txCount;
      for (int b = 0; b < 4; b++) begin
        txStrobe = p[b];
        tick(1);
      end
      check(txCount == c0 + W'($countones(p[3:0])), "R3 one step per strobe", txCount,
            c0 + W'($countones(p[3:0])));
    end
    txStrobe = 1'b1;

    // R4: disable clears both, restart from zero
    tsEnable = 1'b0;
    tick(3);
    check(txCount == '0, "R4 tx cleared", txCount, '0);
    check(rxCount == '0, "R4 rx cleared", rxCount, '0);
    tick(5);
    check(txCount == '0, "R4 tx stays zero", txCount, '0);
    tsEnable = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      check(txCount == ((k >= 2) ? W'(k - 2) : W'(0)), "R4 restart from zero", txCount,
            (k >= 2) ? W'(k - 2) : W'(0));
      checkAlign("R5 alignment after restart");
    end

    // R9: pending schedule dropped by disable
    schedTime = txCount + W'(11);
    schedArm = 1'b1;
    tick(1);
    schedArm = 1'b0;
    tsEnable = 1'b0;
    tick(4);
    tsEnable = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      tick(1);
      if (txEvent) seen = 1'b1;
    end
    check(!seen, "R9 schedule discarded", W'(seen), '0);
    check(txCount > schedTime, "R9 counter passed old time", txCount, schedTime);

    // R6 / R7 / R8: arming offsets around the next count
    for (int d = -3; d <= 5; d++) schedSweep(d);

    // R7 with the counter frozen: equal to current count fires at once
    txStrobe = 1'b0;
    tick(1);
    schedTime = txCount;
    schedArm = 1'b1;
    tick(1);
    schedArm = 1'b0;
    check(txEvent, "R7 frozen equal fires", W'(txEvent), W'(1));
    tick(1);
    check(!txEvent, "R6 no repeat", W'(txEvent), '0);

    // R6: armed while frozen, fires once the counter gets there
    c0 = txCount;
    schedTime = c0 + W'(2);
    schedArm = 1'b1;
    tick(1);
    schedArm = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      if (txEvent) seen = 1'b1;
    end
    check(!seen, "R6 no event while frozen", W'(seen), '0);
    txStrobe = 1'b1;
    tick(1);
    check(!txEvent, "R6 not yet", W'(txEvent), '0);
    tick(1);
    check(txEvent && txCount == c0 + W'(2), "R6 event at target", txCount, c0 + W'(2));
    tick(1);
    check(!txEvent, "R6 pulse one cycle", W'(txEvent), '0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge txClk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule